// File: doc/BRIEF.md
# Combining-Tree Barrier Controller

This block holds a group of processors at a synchronisation point until every one of them has reached it, and then lets all of them go in the same clock cycle. The number of processors, `NUM_PROCS`, must be a power of two and at least 2. Arrivals are not counted by one shared counter. They are merged in pairs over log2(NUM_PROCS) levels of a binary tree.

At level L, the node that stands for processor i (i has its low L bits zero) completes when both of its children have completed. One child is the subtree of i and the other is the subtree of its partner i + 2^(L-1). Each node has a one-bit register. When the root completes, a release is fanned back down the same tree to every processor.

Each processor announces its arrival by driving its toggle input to the inverse of the current episode sense. The episode sense flips each time a barrier completes. As a result, an input that was left at the last episode's value never counts as an arrival, and the barrier can be reused at once.

Top module: `tree_barrier`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `release_o` is all zeros and `sense_o` is 0.
- R2: Processor i counts as arrived while `arrive_tgl_i[i]` differs from `sense_o`. `release_o` stays all zeros for as long as at least one processor has not arrived, however long that is.
- R3: `release_o` is either all zeros or all ones. Every high phase lasts exactly one cycle.
- R4: Let edge k be the first clock edge at which all processors count as arrived. `release_o` is high in the cycle that follows edge k + log2(NUM_PROCS) - 1. This is log2(NUM_PROCS) edges, counting edge k.
- R5: `sense_o` inverts at the same edge at which `release_o` rises, and at no other edge.
- R6: Arrivals combine pairwise per level. The latency of R4 is the same whatever the arrival order, and whether the last processor to arrive is a representative (for example index 0) or a partner (for example index NUM_PROCS-1).
- R7: A toggle for the next episode that is driven in the cycle right after release is counted for the new episode only. Toggles left unchanged after a release produce no further release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_tgl_i | input | NUM_PROCS | Per-processor arrival toggle. A processor has arrived while its bit differs from `sense_o` |
| release_o | output | NUM_PROCS | Per-processor one-cycle release pulse |
| sense_o | output | 1 | Sense of the current episode. It inverts on every completed barrier |

## Verification
A release is due exactly log2(NUM_PROCS) rising edges after the first edge that sees every toggle arrived. The sense flip is due on the same edge. A behavioural model in the bench counts these edges down from the sampled arrivals and predicts both outputs for every cycle. The bench drives inputs and compares outputs on the falling edge, so each comparison falls half a cycle after the register that produced the value. Dedicated checks count the falling edges between the final arrival and the pulse, and they watch long windows where one processor is missing or the toggles are stale.

// File: rtl/tree_barrier_pkg.sv
package tree_barrier_pkg;

    // true when n is a power of two and at least 2
    function automatic bit is_pow2(input int unsigned n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

    // number of live combining nodes at tree level lv (lv >= 1)
    function automatic int unsigned nodes_at(input int unsigned procs, input int unsigned lv);
        return procs >> lv;
    endfunction

endpackage

// File: rtl/tbar_arrival_detect.sv
module tbar_arrival_detect #(
    parameter int unsigned NUM_PROCS = 8
) (
    input  logic [NUM_PROCS-1:0] tgl_i,
    input  logic                 sense_i,
    output logic [NUM_PROCS-1:0] arrived_o
);

    // a processor has arrived once its toggle moved away from the episode sense
    assign arrived_o = tgl_i ^ {NUM_PROCS{sense_i}};

endmodule

// File: rtl/tbar_pair_combine.sv
module tbar_pair_combine
    import tree_barrier_pkg::*;
#(
    parameter int unsigned NUM_PROCS = 8,
    localparam int unsigned LEVELS = $clog2(NUM_PROCS),
    localparam int unsigned HALF   = NUM_PROCS / 2
) (
    input  logic [NUM_PROCS-1:0]          arrived_i,
    input  logic [LEVELS-1:0][HALF-1:0]   done_q_i,
    output logic [LEVELS-1:0][HALF-1:0]   comb_d_o
);

    // the root register and idle slots are read here only to keep every bit accounted for
    logic unused_done;
    assign unused_done = ^done_q_i;

    // level lv node n represents processor n << lv; children are nodes 2n and 2n+1 one level below
    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_lvl
        for (genvar n = 0; n < HALF; n++) begin : g_node
            if (n < nodes_at(NUM_PROCS, lv)) begin : g_live
                if (lv == 1) begin : g_leaf
                    assign comb_d_o[0][n] = arrived_i[2*n] & arrived_i[2*n+1];
                end else begin : g_inner
                    assign comb_d_o[lv-1][n] = done_q_i[lv-2][2*n] & done_q_i[lv-2][2*n+1];
                end
            end else begin : g_idle
                assign comb_d_o[lv-1][n] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tbar_release_fanout.sv
module tbar_release_fanout #(
    parameter int unsigned NUM_PROCS = 8,
    localparam int unsigned LEVELS = $clog2(NUM_PROCS)
) (
    input  logic                 root_i,
    output logic [NUM_PROCS-1:0] release_o
);

    logic [LEVELS:0][NUM_PROCS-1:0] rel_lvl;

    // down-sweep: every node forwards the release of its parent at the level above
    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        for (genvar n = 0; n < NUM_PROCS; n++) begin : g_node
            if (lv == LEVELS) begin : g_root
                if (n == 0) begin : g_top
                    assign rel_lvl[lv][n] = root_i;
                end else begin : g_pad
                    assign rel_lvl[lv][n] = 1'b0;
                end
            end else if (n < (NUM_PROCS >> lv)) begin : g_live
                assign rel_lvl[lv][n] = rel_lvl[lv+1][n>>1];
            end else begin : g_idle
                assign rel_lvl[lv][n] = 1'b0;
            end
        end
    end

    logic unused_rel;
    assign unused_rel = ^rel_lvl[LEVELS:1];

    assign release_o = rel_lvl[0];

endmodule

// File: rtl/tree_barrier.sv
module tree_barrier
    import tree_barrier_pkg::*;
#(
    parameter int unsigned NUM_PROCS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PROCS-1:0] arrive_tgl_i,
    output logic [NUM_PROCS-1:0] release_o,
    output logic                 sense_o
);

    localparam int unsigned LEVELS = $clog2(NUM_PROCS);
    localparam int unsigned HALF   = NUM_PROCS / 2;

    typedef struct packed {
        logic                        sense;
        logic [LEVELS-1:0][HALF-1:0] done;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_PROCS-1:0]        arrived;
    logic [LEVELS-1:0][HALF-1:0] comb_d;
    logic                        root_d;

    tbar_arrival_detect #(.NUM_PROCS(NUM_PROCS)) u_arrive (
        .tgl_i     (arrive_tgl_i),
        .sense_i   (st_q.sense),
        .arrived_o (arrived)
    );

    tbar_pair_combine #(.NUM_PROCS(NUM_PROCS)) u_combine (
        .arrived_i (arrived),
        .done_q_i  (st_q.done),
        .comb_d_o  (comb_d)
    );

    tbar_release_fanout #(.NUM_PROCS(NUM_PROCS)) u_fanout (
        .root_i    (st_q.done[LEVELS-1][0]),
        .release_o (release_o)
    );

    assign root_d = comb_d[LEVELS-1][0];

    always_comb begin
        st_d      = st_q;
        st_d.done = comb_d;
        if (root_d) begin
            // episode completes: flip sense and wipe the partial combinations below the root
            st_d.sense = ~st_q.sense;
            for (int lv = 0; lv < int'(LEVELS) - 1; lv++) begin
                st_d.done[lv] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sense_o = st_q.sense;

endmodule

// File: rtl/tree_barrier_chk.sv
module tree_barrier_chk #(
    parameter int unsigned NUM_PROCS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PROCS-1:0] arrive_tgl_i,
    input logic [NUM_PROCS-1:0] release_o,
    input logic                 sense_o
);

    // R3: all processors leave together
    a_r3_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o == '0) || (release_o == '1));

    // R3: release is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |=> (release_o == '0));

    // R2: a release needs every processor arrived at the completing edge
    a_r2_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |-> $past(&(arrive_tgl_i ^ {NUM_PROCS{sense_o}})));

    // R5: sense changes only together with a release
    a_r5_flip_only_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_o != $past(sense_o)) |-> release_o[0]);

    // R5: every release flips the sense
    a_r5_release_flips: assert property (@(posedge clk) disable iff (!rst_n)
        release_o[0] |-> (sense_o != $past(sense_o)));

endmodule

bind tree_barrier tree_barrier_chk #(.NUM_PROCS(NUM_PROCS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arrive_tgl_i (arrive_tgl_i),
    .release_o    (release_o),
    .sense_o      (sense_o)
);

// File: tb/test_tree_barrier.sv
module test_tree_barrier;

    localparam int    P      = 8;
    localparam int    LEVELS = $clog2(P);
    localparam time   T_CLK  = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] tgl = '0;
    logic [P-1:0] release_o;
    logic         sense_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model state
    bit m_sense = 0;
    bit m_rel   = 0;
    int m_cnt   = -1;

    always #(T_CLK/2) clk = ~clk;

    tree_barrier #(.NUM_PROCS(P)) i_tree_barrier (
        .clk          (clk),
        .rst_n        (rst_n),
        .arrive_tgl_i (tgl),
        .release_o    (release_o),
        .sense_o      (sense_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: counts edges from the first all-arrived sample
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sense = 0; m_rel = 0; m_cnt = -1;
        end else begin
            m_rel = 0;
            if (m_cnt == -1 && ((tgl ^ {P{m_sense}}) == '1)) m_cnt = LEVELS - 1;
            if (m_cnt == 0) begin
                m_rel = 1; m_sense = ~m_sense; m_cnt = -1;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(release_o == {P{m_rel}}, "R3/R4 release", release_o, {P{m_rel}});
            check(sense_o == m_sense, "R5 sense", sense_o, m_sense);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arrive(input int i);
        tgl[i] = ~m_sense;
    endtask

    task automatic wait_release();
        do @(negedge clk); while (!m_rel);
    endtask

    // R4: count falling edges from the last arrival to the pulse
    task automatic last_arrive_latency(input int i, input string tag);
        int edges = 0;
        arrive(i);
        do begin @(negedge clk); edges++; end while (release_o == '0 && edges < 20);
        check(edges == LEVELS, tag, edges, LEVELS);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(2);
        // R1: values held in reset
        check(release_o == '0, "R1 release in reset", release_o, 0);
        check(sense_o == 1'b0, "R1 sense in reset", sense_o, 0);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check(release_o == '0 && sense_o == 1'b0, "R1 after reset", {release_o, sense_o}, 0);

        // ascending arrivals, one per cycle, last is partner P-1 (R6)
        for (int i = 0; i < P - 1; i++) begin arrive(i); tick(1); end
        last_arrive_latency(P - 1, "R4 R6 partner last latency");
        tick(3);

        // descending with gaps, representative 0 last (R6)
        for (int i = P - 1; i > 0; i--) begin arrive(i); tick(3); end
        last_arrive_latency(0, "R6 representative last latency");
        tick(3);

        // all together (R4)
        for (int i = 0; i < P - 1; i++) arrive(i);
        last_arrive_latency(P - 1, "R4 simultaneous latency");
        tick(2);

        // one processor missing for a long time (R2)
        for (int i = 0; i < P; i++) if (i != 5) arrive(i);
        for (int c = 0; c < 30; c++) begin
            tick(1);
            check(release_o == '0, "R2 held while 5 absent", release_o, 0);
        end
        check(sense_o == m_sense, "R2 sense unchanged while waiting", sense_o, m_sense);
        last_arrive_latency(5, "R4 R6 middle last latency");

        // stale toggles after release: no further release (R7)
        for (int c = 0; c < 15; c++) begin
            tick(1);
            check(release_o == '0, "R7 stale toggles ignored", release_o, 0);
        end

        // immediate re-arrival right after the pulse (R7)
        for (int i = 0; i < P; i++) arrive(i);
        wait_release();
        for (int i = 0; i < P - 1; i++) arrive(i);
        check(release_o == '1, "R3 pulse visible", release_o, '1);
        last_arrive_latency(P - 1, "R7 back-to-back episode latency");
        for (int i = 0; i < P; i++) arrive(i);
        tick(1);
        check(release_o == '0, "R3 pulse is one cycle", release_o, 0);
        wait_release();
        tick(4);

        // interleaved pair order: partners first, then representatives
        for (int i = 1; i < P; i += 2) begin arrive(i); tick(1); end
        for (int i = 0; i < P - 2; i += 2) begin arrive(i); tick(2); end
        last_arrive_latency(P - 2, "R6 interleaved order latency");
        tick(5);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule